// File: doc/BRIEF.md
# Three-Channel Reloadable Down-Counter Timer

This block holds three independent 32-bit down-counters behind a small synchronous register port. Each channel has a reload constant, a live count and a control word. While a channel's run bit is set, a per-channel prescaler divides the peripheral-clock enable by a power of four. Each prescaler terminal count produces one count tick. A tick at zero reloads the count from the constant instead of decrementing it. It also sets a sticky underflow flag, which can drive that channel's interrupt line.

Software programs the block through a byte address, a write strobe and a 32-bit write data bus. Reads are combinational from the addressed register. Writes take effect on the next rising clock edge.

Top module: `tri_timer`

## Requirements
- R1: After reset every constant and count register reads 0xFFFFFFFF. Every control register, the run register at 0x04 and the output-control register at 0x00 read zero, and all interrupt lines are low.
- R2: Channel N places its constant at byte offset 0x08+12N, its count at 0x0C+12N and its control at 0x10+12N. The 32-bit registers keep all written bits. The control register keeps the low 16 bits, and the registers at 0x00 and 0x04 keep the low 8 bits.
- R3: Bit N of the run register at 0x04 lets channel N count. With that bit clear the channel holds its count.
- R4: Control bits [2:0] with value k from 0 to 4 give one tick every 4^(k+1) enabled clock cycles. The first decrement comes on the 4^(k+1)-th enabled edge after the run bit is set.
- R5: Control bits [2:0] of 5, 6 or 7 produce no ticks. The count holds and the flag stays clear.
- R6: Prescalers advance only on clock edges where `pclkEn` is high.
- R7: A tick with the count at zero loads the constant into the count and sets control bit 8, the underflow flag. A tick at any other value decrements the count by one.
- R8: The flag is sticky. Only a control write with bit 8 clear clears it. An underflow in the same cycle as such a write leaves the flag set.
- R9: `irq[N]` is high exactly while channel N's control bit 8 (flag) and bit 5 (interrupt enable) are both set.
- R10: A control write that changes bits [2:0] restarts that channel's prescaler from zero. A control write that leaves bits [2:0] unchanged does not disturb it.
- R11: A count write lands even when a tick falls on the same edge, and the tick is lost.
- R12: Reads of 0x2C and of any other unmapped offset return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pclkEn | input | 1 | Peripheral-clock enable; one prescaler step per high cycle |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wrEn | input | 1 | Write strobe |
| wrData | input | CNT_W (32) | Write data |
| rdData | output | CNT_W (32) | Read data of the addressed register, combinational |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
On every cycle the assertions check the following for each channel:
- a stopped channel or one with an unsupported rate holds its count unless software writes it;
- any other change of the count is a single decrement or a reload from zero to the constant;
- the flag never drops without a control write;
- the flag only rises by itself when the count was zero.

Only the directed scenarios can show the following:
- the exact tick spacing for each divisor;
- the prescaler restart on a rate change;
- the precedence rules when a write and a tick share an edge;
- the register map, the reset values and the interrupt gating.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  localparam int NUM_CH      = 3;
  localparam int SEL_W       = 3;
  localparam int MAX_SEL     = 4;
  localparam int PRE_W       = 2 * MAX_SEL + 2;
  localparam int CTL_W       = 16;
  localparam int BYTE_W      = 8;
  localparam int FLAG_BIT    = 8;
  localparam int IE_BIT      = 5;
  localparam int OFF_OUTCTL  = 'h00;
  localparam int OFF_RUN     = 'h04;
  localparam int OFF_CH_BASE = 'h08;
  localparam int CH_STRIDE   = 12;

  typedef struct packed {
    logic              outCtlWr;
    logic              runWr;
    logic [NUM_CH-1:0] constWr;
    logic [NUM_CH-1:0] cntWr;
    logic [NUM_CH-1:0] ctlWr;
  } wr_strobe_t;

  // Terminal prescaler value for a rate select; zero for unsupported codes.
  function automatic logic [PRE_W-1:0] preTerminal(input logic [SEL_W-1:0] sel);
    int shamt;
    shamt = 2 * int'(sel) + 2;
    if (sel > SEL_W'(MAX_SEL)) return '0;
    return PRE_W'((32'd1 << shamt) - 32'd1);
  endfunction

endpackage

// File: rtl/tri_timer_ctl.sv
module tri_timer_ctl
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wrEn,
  input  logic [BYTE_W-1:0]             outCtlQ,
  input  logic [BYTE_W-1:0]             startQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  constQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cntQ,
  input  logic [NUM_CH-1:0][CTL_W-1:0]  ctlQ,
  output wr_strobe_t                    strobe,
  output logic [CNT_W-1:0]              rdData
);

  // Address decode: one strobe per register, readback mux, zero elsewhere.
  always_comb begin
    strobe = '0;
    rdData = '0;
    if (addr == ADDR_W'(OFF_OUTCTL)) begin
      strobe.outCtlWr = wrEn;
      rdData          = CNT_W'(outCtlQ);
    end
    if (addr == ADDR_W'(OFF_RUN)) begin
      strobe.runWr = wrEn;
      rdData       = CNT_W'(startQ);
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE * n)) begin
        strobe.constWr[n] = wrEn;
        rdData            = constQ[n];
      end
      if (addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE * n + 4)) begin
        strobe.cntWr[n] = wrEn;
        rdData          = cntQ[n];
      end
      if (addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE * n + 8)) begin
        strobe.ctlWr[n] = wrEn;
        rdData          = CNT_W'(ctlQ[n]);
      end
    end
  end

endmodule

// File: rtl/tri_timer_dp.sv
module tri_timer_dp
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pclkEn,
  input  wr_strobe_t                    strobe,
  input  logic [CNT_W-1:0]              wrData,
  output logic [BYTE_W-1:0]             outCtlQ,
  output logic [BYTE_W-1:0]             startQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]  constQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntQ,
  output logic [NUM_CH-1:0][CTL_W-1:0]  ctlQ,
  output logic [NUM_CH-1:0]             irq
);

  localparam logic [CNT_W-1:0] CNT_RST = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCtlQ <= '0;
      startQ  <= '0;
    end else begin
      if (strobe.outCtlWr) outCtlQ <= wrData[BYTE_W-1:0];
      if (strobe.runWr)    startQ  <= wrData[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [PRE_W-1:0] preR;
    logic [CNT_W-1:0] constR;
    logic [CNT_W-1:0] cntR;
    logic [CTL_W-1:0] ctlR;
    logic [SEL_W-1:0] selNow;
    logic             selOk;
    logic             selChg;
    logic             advance;
    logic             tick;
    logic             underflow;

    assign selNow    = ctlR[SEL_W-1:0];
    assign selOk     = selNow <= SEL_W'(MAX_SEL);
    assign selChg    = strobe.ctlWr[g] && (wrData[SEL_W-1:0] != selNow);
    assign advance   = startQ[g] && pclkEn && selOk;
    assign tick      = advance && !selChg && (preR == preTerminal(selNow));
    assign underflow = tick && (cntR == '0);

    // Prescaler: counts enabled cycles, wraps at the selected terminal.
    always_ff @(posedge clk) begin
      if (!rstN)        preR <= '0;
      else if (selChg)  preR <= '0;
      else if (tick)    preR <= '0;
      else if (advance) preR <= preR + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  constR <= CNT_RST;
      else if (strobe.constWr[g]) constR <= wrData;
    end

    // Count: software write wins over the tick on the same edge.
    always_ff @(posedge clk) begin
      if (!rstN)                cntR <= CNT_RST;
      else if (strobe.cntWr[g]) cntR <= wrData;
      else if (underflow)       cntR <= constR;
      else if (tick)            cntR <= cntR - 1'b1;
    end

    // Control: an underflow sets the flag even against a clearing write.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctlR <= '0;
      end else begin
        if (strobe.ctlWr[g]) ctlR <= wrData[CTL_W-1:0];
        if (underflow)       ctlR[FLAG_BIT] <= 1'b1;
      end
    end

    assign constQ[g] = constR;
    assign cntQ[g]   = cntR;
    assign ctlQ[g]   = ctlR;
    assign irq[g]    = ctlR[FLAG_BIT] & ctlR[IE_BIT];
  end

endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pclkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);

  wr_strobe_t                   strobe;
  logic [BYTE_W-1:0]            outCtlQ;
  logic [BYTE_W-1:0]            startQ;
  logic [NUM_CH-1:0][CNT_W-1:0] constQ;
  logic [NUM_CH-1:0][CNT_W-1:0] cntQ;
  logic [NUM_CH-1:0][CTL_W-1:0] ctlQ;

  tri_timer_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtl (
    .addr    (addr),
    .wrEn    (wrEn),
    .outCtlQ (outCtlQ),
    .startQ  (startQ),
    .constQ  (constQ),
    .cntQ    (cntQ),
    .ctlQ    (ctlQ),
    .strobe  (strobe),
    .rdData  (rdData)
  );

  tri_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .pclkEn  (pclkEn),
    .strobe  (strobe),
    .wrData  (wrData),
    .outCtlQ (outCtlQ),
    .startQ  (startQ),
    .constQ  (constQ),
    .cntQ    (cntQ),
    .ctlQ    (ctlQ),
    .irq     (irq)
  );

endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input wr_strobe_t                    strobe,
  input logic [BYTE_W-1:0]             startQ,
  input logic [NUM_CH-1:0][CNT_W-1:0]  constQ,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntQ,
  input logic [NUM_CH-1:0][CTL_W-1:0]  ctlQ
);

  for (genvar n = 0; n < NUM_CH; n++) begin : gChk
    // R3: a stopped channel keeps its count unless software writes it
    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!startQ[n] && !strobe.cntWr[n]) |=> $stable(cntQ[n]));

    // R5: unsupported rate codes never move the count
    p_reserved_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      ((ctlQ[n][SEL_W-1:0] > SEL_W'(MAX_SEL)) && !strobe.cntWr[n] && !strobe.ctlWr[n])
        |=> $stable(cntQ[n]));

    // R7: without a write the count only holds, steps down by one, or reloads from zero
    p_step_or_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.cntWr[n] |=>
        ((cntQ[n] == $past(cntQ[n])) ||
         (cntQ[n] == CNT_W'($past(cntQ[n]) - 1'b1)) ||
         (($past(cntQ[n]) == '0) && (cntQ[n] == $past(constQ[n])))));

    // R7: the flag rises by itself only out of a zero count
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!ctlQ[n][FLAG_BIT] && !strobe.ctlWr[n]) |=>
        (!ctlQ[n][FLAG_BIT] || ($past(cntQ[n]) == '0)));

    // R8: the flag never drops without a control write
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ctlQ[n][FLAG_BIT] && !strobe.ctlWr[n]) |=> ctlQ[n][FLAG_BIT]);
  end

endmodule

bind tri_timer tri_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .strobe (strobe),
  .startQ (startQ),
  .constQ (constQ),
  .cntQ   (cntQ),
  .ctlQ   (ctlQ)
);

// File: tb/tb_tri_timer.sv
module tb_tri_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pclkEn = 1'b1;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  irq;

  int nChecks = 0;
  int nErrs   = 0;

  tri_timer dut (
    .clk(clk), .rstN(rstN), .pclkEn(pclkEn), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] aConst(input int n); return 8'(8 + 12 * n);  endfunction
  function automatic logic [7:0] aCnt(input int n);   return 8'(12 + 12 * n); endfunction
  function automatic logic [7:0] aCtl(input int n);   return 8'(16 + 12 * n); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pclkEn = 1'b1; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic tResetState();
    doReset();
    for (int n = 0; n < 3; n++) begin
      expectReg("R1 const", aConst(n), 32'hFFFF_FFFF);
      expectReg("R1 count", aCnt(n), 32'hFFFF_FFFF);
      expectReg("R1 ctl", aCtl(n), 32'h0);
    end
    expectReg("R1 run", 8'h04, 32'h0);
    expectReg("R1 outctl", 8'h00, 32'h0);
    check("R1 irq", {29'b0, irq}, 32'h0);
  endtask

  task automatic tRegMap();
    doReset();
    for (int n = 0; n < 3; n++) begin
      wr(aConst(n), 32'hA000_0000 + 32'(n));
      wr(aCnt(n), 32'hB000_0000 + 32'(n));
      wr(aCtl(n), 32'h1234_0A03);
    end
    wr(8'h00, 32'h0000_01AB);
    wr(8'h04, 32'h0000_01F0);
    for (int n = 0; n < 3; n++) begin
      expectReg("R2 const", aConst(n), 32'hA000_0000 + 32'(n));
      expectReg("R2 count", aCnt(n), 32'hB000_0000 + 32'(n));
      expectReg("R2 ctl 16-bit", aCtl(n), 32'h0000_0A03);
    end
    expectReg("R2 outctl 8-bit", 8'h00, 32'h0000_00AB);
    expectReg("R2 run 8-bit", 8'h04, 32'h0000_00F0);
  endtask

  task automatic tRunBits();
    doReset();
    wr(aCnt(0), 32'd10);
    wr(aCnt(1), 32'd10);
    wr(8'h04, 32'h1);
    step(8);
    expectReg("R3 ch0 runs", aCnt(0), 32'd8);
    expectReg("R3 ch1 holds", aCnt(1), 32'd10);
    wr(8'h04, 32'h0);
    step(20);
    expectReg("R3 ch0 holds after stop", aCnt(0), 32'd8);
  endtask

  task automatic tRates();
    doReset();
    wr(aCtl(0), 32'd4); wr(aCnt(0), 32'd50);
    wr(aCtl(1), 32'd1); wr(aCnt(1), 32'd1000);
    wr(aCtl(2), 32'd2); wr(aCnt(2), 32'd50);
    wr(8'h04, 32'h7);
    step(15);
    expectReg("R4 div16 before", aCnt(1), 32'd1000);
    step(1);
    expectReg("R4 div16 edge", aCnt(1), 32'd999);
    step(47);
    expectReg("R4 div64 before", aCnt(2), 32'd50);
    step(1);
    expectReg("R4 div64 edge", aCnt(2), 32'd49);
    step(959);
    expectReg("R4 div1024 before", aCnt(0), 32'd50);
    step(1);
    expectReg("R4 div1024 edge", aCnt(0), 32'd49);
    expectReg("R4 div16 after 1024", aCnt(1), 32'd936);
    expectReg("R4 div64 after 1024", aCnt(2), 32'd34);
  endtask

  task automatic tReserved();
    doReset();
    for (int n = 0; n < 3; n++) begin
      wr(aCtl(n), 32'(5 + n));
      wr(aCnt(n), 32'd3);
    end
    wr(8'h04, 32'h7);
    step(1100);
    for (int n = 0; n < 3; n++) begin
      expectReg("R5 count holds", aCnt(n), 32'd3);
      expectReg("R5 flag clear", aCtl(n), 32'(5 + n));
    end
  endtask

  task automatic tGate();
    doReset();
    wr(aCnt(0), 32'd20);
    wr(8'h04, 32'h1);
    pclkEn = 1'b0;
    step(40);
    expectReg("R6 no enable", aCnt(0), 32'd20);
    for (int i = 0; i < 6; i++) begin
      pclkEn = (i % 2 == 0);
      @(negedge clk);
    end
    expectReg("R6 three enables", aCnt(0), 32'd20);
    pclkEn = 1'b1;
    @(negedge clk);
    expectReg("R6 fourth enable", aCnt(0), 32'd19);
  endtask

  task automatic tUnderflowSticky();
    doReset();
    wr(aConst(0), 32'd3);
    wr(aCnt(0), 32'd1);
    wr(8'h04, 32'h1);
    step(4);
    expectReg("R7 at zero", aCnt(0), 32'd0);
    step(3);
    expectReg("R7 no flag yet", aCtl(0), 32'h0);
    step(1);
    expectReg("R7 reload", aCnt(0), 32'd3);
    expectReg("R7 flag set", aCtl(0), 32'h0100);
    step(4);
    expectReg("R7 decrement after reload", aCnt(0), 32'd2);
    expectReg("R8 flag stays", aCtl(0), 32'h0100);
    wr(aCtl(0), 32'h0);
    expectReg("R8 cleared by write", aCtl(0), 32'h0);
    // simultaneous clear write and underflow
    doReset();
    wr(aConst(0), 32'd5);
    wr(aCnt(0), 32'd0);
    wr(8'h04, 32'h1);
    step(3);
    wr(aCtl(0), 32'h0);
    expectReg("R8 set wins over clear", aCtl(0), 32'h0100);
    expectReg("R7 reload on shared edge", aCnt(0), 32'd5);
  endtask

  task automatic tIrq();
    doReset();
    wr(aCtl(0), 32'h0020);
    wr(aConst(0), 32'd7);
    wr(aCnt(0), 32'd0);
    wr(8'h04, 32'h1);
    check("R9 low before underflow", {29'b0, irq}, 32'h0);
    step(4);
    check("R9 high on flag and enable", {29'b0, irq}, 32'h1);
    wr(aCtl(0), 32'h0100);
    check("R9 low with enable off", {29'b0, irq}, 32'h0);
    wr(aCtl(0), 32'h0120);
    check("R9 high again", {29'b0, irq}, 32'h1);
    wr(aCtl(0), 32'h0020);
    check("R9 low after flag clear", {29'b0, irq}, 32'h0);
  endtask

  task automatic tSelClear();
    doReset();
    wr(aCnt(0), 32'd50);
    wr(8'h04, 32'h1);
    step(2);
    wr(aCtl(0), 32'h1);
    wr(aCtl(0), 32'h0);
    step(3);
    expectReg("R10 restart before", aCnt(0), 32'd50);
    step(1);
    expectReg("R10 restart edge", aCnt(0), 32'd49);
    step(2);
    wr(aCtl(0), 32'h0);
    expectReg("R10 same select keeps phase", aCnt(0), 32'd49);
    step(1);
    expectReg("R10 same select tick", aCnt(0), 32'd48);
  endtask

  task automatic tOverride();
    doReset();
    wr(aCnt(0), 32'd50);
    wr(8'h04, 32'h1);
    step(3);
    wr(aCnt(0), 32'd100);
    expectReg("R11 write wins", aCnt(0), 32'd100);
    step(3);
    expectReg("R11 next phase before", aCnt(0), 32'd100);
    step(1);
    expectReg("R11 next tick", aCnt(0), 32'd99);
  endtask

  task automatic tUnmapped();
    doReset();
    wr(8'h2C, 32'h1234_5678);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    expectReg("R12 read 0x2C", 8'h2C, 32'h0);
    expectReg("R12 read 0x30", 8'h30, 32'h0);
    expectReg("R12 read 0x02", 8'h02, 32'h0);
    for (int n = 0; n < 3; n++) begin
      expectReg("R12 const untouched", aConst(n), 32'hFFFF_FFFF);
      expectReg("R12 count untouched", aCnt(n), 32'hFFFF_FFFF);
      expectReg("R12 ctl untouched", aCtl(n), 32'h0);
    end
    expectReg("R12 run untouched", 8'h04, 32'h0);
    expectReg("R12 outctl untouched", 8'h00, 32'h0);
    check("R12 irq", {29'b0, irq}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErrs++;
    nChecks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    tResetState();
    tRegMap();
    tRunBits();
    tRates();
    tReserved();
    tGate();
    tUnderflowSticky();
    tIrq();
    tSelClear();
    tOverride();
    tUnmapped();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule